// File: doc/BRIEF.md
# I2C Counted Burst Receiver

This block clocks a counted burst of bytes in from an I2C target while acting as the bus controller. It generates SCL for each bit. It samples SDA MSB first and answers every byte in its ninth clock. The answer is normally ACK. The final byte of a burst can instead be answered with NAK when software asks for it. Because the NAK choice is made per burst, a long read can be split into chunks of at most 64 bytes, and only the closing chunk ends in NAK.

Software uses a small register port to drive it. A write to the control register arms a burst with a count and the NAK choice. When the last byte has been answered, a sticky completion flag is raised, and that flag can also drive an interrupt line. Received bytes wait in a 64-entry FIFO. Each read of the data register takes the oldest byte out of it. START, STOP and addressing are handled elsewhere. This block only runs the data phase of a read.

Top module: `rx_burst_reader`

## Requirements
- R1: After reset, SCL and SDA are both released (drive-low outputs at 0), `irq` is 0, the completion flag reads 0, and the FIFO reads as empty.
- R2: A write to address 0 sets the count from bits [6:0] and the final-NAK choice from bit 7. If the block is idle and the count is nonzero, a burst of that many bytes starts. Each byte takes 9 SCL clocks, and each SCL clock takes 4*CLK_DIV cycles, low for the first half and high for the second. Counts above 64 are treated as 64.
- R3: Bits are sampled MSB first. Bytes enter the FIFO in the order they arrive. Each read of address 4 with `reg_rd` high returns the oldest byte and then removes it.
- R4: During the ninth clock of each byte, SDA is driven low (ACK). The exception is the last byte of a burst whose final-NAK bit was set: there SDA stays released (NAK).
- R5: The completion flag reads at address 2 bit 4. It is set exactly n*36*CLK_DIV cycles after the edge that accepted a burst of n bytes. Writing 1 to bit 4 clears it. Writing 0 leaves it unchanged.
- R6: `irq` is high exactly when the completion flag is set and the enable bit (address 1 bit 4) is 1.
- R7: Address 3 bit 2 reads 1 when the FIFO is empty and 0 otherwise.
- R8: A data read while the FIFO is empty returns 0 and removes nothing. Later bytes are still returned correctly.
- R9: A control write with count 0 produces no SCL activity and does not set the completion flag.
- R10: A control write during a burst is ignored. The running burst keeps its count and its NAK choice.
- R11: The FIFO never holds more than 64 bytes. A byte that arrives while the FIFO is full is discarded, and the bytes already stored are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 4) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq | output | 1 | Completion interrupt |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The completion flag is due n*36*CLK_DIV cycles after the accepting edge. The bench keeps a free-running cycle count, polls the flag at falling clock edges, and compares the cycle at which it first appears with that exact figure. This covers clamped bursts and bursts that were poked mid-run. Register reads are combinational. Each pop is sampled just after the falling edge that precedes the popping rising edge, so data, empty status and `irq` are checked in the same half-cycle as the register access. ACK levels and SCL rise counts come from a bench target model that tracks each bit slot and rising SCL edge.

// File: rtl/rx_burst_reader.sv
module rx_burst_reader #(
  parameter int DEPTH   = 64,
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  input  logic       sda_in
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic          busy, nak_en, done, ien;
  logic [6:0]    left;
  logic [1:0]    ph;
  logic [DW-1:0] tick;
  logic [3:0]    bit_idx;
  logic [6:0]    shreg;
  logic [7:0]    ctl_q;
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] wp, rp, level;

  wire       wr_ctl   = reg_wr && reg_addr == 3'd0;
  wire [6:0] cnt_req  = (reg_wdata[6:0] > 7'(DEPTH)) ? 7'(DEPTH) : reg_wdata[6:0];
  wire       start    = wr_ctl && !busy && cnt_req != 7'd0;
  wire       tick_end = tick == DW'(CLK_DIV - 1);
  wire       sample   = busy && ph == 2'd2 && tick_end;
  wire       bit_end  = busy && ph == 2'd3 && tick_end;
  wire       last     = left == 7'd1;
  wire       empty    = wp == rp;
  wire       full     = level == CW'(DEPTH);
  wire       push     = sample && bit_idx == 4'd7 && !full;
  wire       pop      = reg_rd && reg_addr == 3'd4 && !empty;

  assign level         = wp - rp;
  assign scl_drive_low = busy && !ph[1];
  assign sda_drive_low = busy && bit_idx == 4'd8 && ph != 2'd0 && !(last && nak_en);
  assign irq           = done && ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      nak_en  <= 1'b0;
      done    <= 1'b0;
      ien     <= 1'b0;
      left    <= '0;
      ph      <= '0;
      tick    <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      ctl_q   <= '0;
    end else begin
      if (reg_wr && reg_addr == 3'd2 && reg_wdata[4]) done <= 1'b0;
      if (reg_wr && reg_addr == 3'd1) ien <= reg_wdata[4];
      if (wr_ctl && !busy) ctl_q <= reg_wdata;
      if (start) begin
        busy    <= 1'b1;
        left    <= cnt_req;
        nak_en  <= reg_wdata[7];
        ph      <= '0;
        tick    <= '0;
        bit_idx <= '0;
      end else if (busy) begin
        tick <= tick_end ? '0 : tick + 1'b1;
        if (tick_end) ph <= ph + 2'd1;
        if (sample) shreg <= {shreg[5:0], sda_in};
        if (bit_end) begin
          if (bit_idx == 4'd8) begin
            bit_idx <= '0;
            left    <= left - 7'd1;
            if (last) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end else begin
            bit_idx <= bit_idx + 4'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= {shreg, sda_in};
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = ctl_q;
      3'd1:    reg_rdata = {3'b0, ien, 4'b0};
      3'd2:    reg_rdata = {3'b0, done, 4'b0};
      3'd3:    reg_rdata = {5'b0, empty, 2'b0};
      3'd4:    reg_rdata = empty ? 8'h00 : mem[rp[AW-1:0]];
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

module rx_burst_reader_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] level,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic [7:0]    reg_rdata,
  input logic          scl_drive_low,
  input logic          sda_drive_low
);
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  a_r5_flag_at_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  a_r4_sda_moves_with_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(sda_drive_low)) |-> scl_drive_low);

  a_r9_zero_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[6:0] == 7'd0 && !busy) |=> (!busy && !$rose(done)));

  a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd4 && level == '0) |-> reg_rdata == 8'h00);

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_drive_low && !sda_drive_low));
endmodule

bind rx_burst_reader rx_burst_reader_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .level(level),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
);

// File: tb/rx_burst_reader_bench.sv
module rx_burst_reader_bench;
  localparam int DIV = 4;
  localparam int BYTE_CYC = 36 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, scl_low, sda_low;
  logic       sda_in = 1'b1;

  rx_burst_reader #(.DEPTH(64), .CLK_DIV(DIV)) u_rx_burst_reader (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_drive_low(scl_low), .sda_drive_low(sda_low), .sda_in(sda_in)
  );

  always #5 clk = ~clk;

  int total = 0, fails = 0, cyc = 0;
  int seed = 0, byte_idx = 0, rises = 0, cur_slot = 0, nxt_slot = 0;
  logic ack_seen [128];
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat(input int s, input int k);
    return 8'(k * 29 + s * 7 + 3);
  endfunction

  initial forever begin
    logic [7:0] b;
    @(posedge scl_low);
    cur_slot = nxt_slot;
    b = pat(seed, byte_idx);
    sda_in = (cur_slot < 8) ? b[7 - cur_slot] : 1'b1;
    nxt_slot = (cur_slot == 8) ? 0 : cur_slot + 1;
  end

  initial forever begin
    @(negedge scl_low);
    rises++;
    if (cur_slot == 8) begin
      if (byte_idx < 128) ack_seen[byte_idx] = sda_low;
      byte_idx++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic pop(output logic [7:0] v);
    @(negedge clk);
    reg_addr = 3'd4; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic run_burst(input logic [7:0] ctl, input int n, input bit nak, input int s,
                           input bit poke, input bit drain);
    int t0, bad;
    logic [7:0] v;
    seed = s; byte_idx = 0; rises = 0; nxt_slot = 0;
    wr(3'd0, ctl);
    t0 = cyc;
    peek(3'd2, v);
    while (!v[4]) begin
      @(negedge clk);
      if (poke && cyc - t0 == 50) wr(3'd0, 8'h85);
      peek(3'd2, v);
    end
    chk(cyc - t0 == n * BYTE_CYC, "R5 completion timing", cyc - t0, n * BYTE_CYC);
    chk(rises == n * 9, "R2 SCL clock count", rises, n * 9);
    bad = 0;
    for (int k = 0; k < n; k++)
      if (ack_seen[k] != !(nak && k == n - 1)) bad++;
    chk(bad == 0, (poke ? "R10 ACK/NAK kept after poke" : "R4 ACK/NAK pattern"), bad, 0);
    if (drain) begin
      bad = 0;
      for (int k = 0; k < n; k++) begin
        pop(v);
        if (v != pat(s, k)) bad++;
      end
      chk(bad == 0, "R3 data order", bad, 0);
      peek(3'd3, v);
      chk(v[2] == 1'b1, "R7 empty after drain", int'(v[2]), 1);
    end
    wr(3'd2, 8'h00);
    peek(3'd2, v);
    chk(v[4] == 1'b1, "R5 write 0 keeps flag", int'(v[4]), 1);
    wr(3'd2, 8'h10);
    peek(3'd2, v);
    chk(v[4] == 1'b0, "R5 write 1 clears flag", int'(v[4]), 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 and R7 after reset
    chk(!scl_low && !sda_low, "R1 lines released", int'({scl_low, sda_low}), 0);
    chk(!irq, "R1 irq low", int'(irq), 0);
    peek(3'd2, v);
    chk(v[4] == 1'b0, "R1 flag clear", int'(v[4]), 0);
    peek(3'd3, v);
    chk(v[2] == 1'b1, "R7 empty at reset", int'(v[2]), 1);

    // R8 empty read
    pop(v);
    chk(v == 8'h00, "R8 empty read zero", v, 0);

    run_burst(8'h81, 1, 1'b1, 1, 1'b0, 1'b1);
    run_burst(8'h02, 2, 1'b0, 2, 1'b0, 1'b1);
    run_burst(8'h85, 5, 1'b1, 3, 1'b0, 1'b1);
    run_burst(8'hC0, 64, 1'b1, 4, 1'b0, 1'b1);

    // R2 clamp
    run_burst(8'h64, 64, 1'b0, 5, 1'b0, 1'b1);

    // R10 poke during burst
    run_burst(8'h02, 2, 1'b0, 6, 1'b1, 1'b1);

    // R6 interrupt gating
    wr(3'd1, 8'h10);
    seed = 7; byte_idx = 0; rises = 0; nxt_slot = 0;
    wr(3'd0, 8'h81);
    repeat (BYTE_CYC + 2) @(negedge clk);
    chk(irq == 1'b1, "R6 irq with enable", int'(irq), 1);
    wr(3'd1, 8'h00);
    chk(irq == 1'b0, "R6 irq masked", int'(irq), 0);
    wr(3'd1, 8'h10);
    wr(3'd2, 8'h10);
    chk(irq == 1'b0, "R6 irq after clear", int'(irq), 0);
    wr(3'd1, 8'h00);
    pop(v);
    chk(v == pat(7, 0), "R8 data after empty read", v, pat(7, 0));

    // R9 zero count
    rises = 0;
    wr(3'd0, 8'h80);
    repeat (200) @(negedge clk);
    chk(rises == 0, "R9 no SCL for zero count", rises, 0);
    peek(3'd2, v);
    chk(v[4] == 1'b0, "R9 no flag for zero count", int'(v[4]), 0);

    // R11 overflow: fill, then one more byte
    run_burst(8'h40, 64, 1'b0, 8, 1'b0, 1'b0);
    peek(3'd3, v);
    chk(v[2] == 1'b0, "R7 not empty when filled", int'(v[2]), 0);
    run_burst(8'h81, 1, 1'b1, 9, 1'b0, 1'b0);
    begin
      int bad = 0;
      for (int k = 0; k < 64; k++) begin
        pop(v);
        if (v != pat(8, k)) bad++;
      end
      chk(bad == 0, "R11 stored bytes kept", bad, 0);
    end
    pop(v);
    chk(v == 8'h00, "R11 extra byte discarded", v, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule